// File: doc/BRIEF.md
# Privileged Control Register File

This block keeps a small set of control and status registers for a processor core and carries out the read-modify-write accesses that the core's register-access instructions ask for. Each cycle the core presents one access: a 12-bit register address, an operation, a write operand, a flag saying that the operand comes from the hard-wired zero register, and the core's current privilege mode. In the same cycle the block returns the register's old value. If the access is not allowed, it raises an illegal-access flag instead. A legal write takes effect on the next rising clock edge.

The rights for each access come from the address itself. Bits [11:10] equal to 2'b11 make a register read-only. Bits [9:8] give the lowest privilege mode that may touch it. Inside a writable register, some fields are fixed, and a write leaves those fields at their value without raising any error. The block holds seven registers:

| Address | Contents | Writable bits | Reset value |
|---|---|---|---|
| 0x040 | user flags | [7:0] | 0xA500_0000 |
| 0x140 | supervisor scratch | all | 0 |
| 0x240 | hypervisor scratch | all | 0 |
| 0x300 | machine control | [15:0] | 0x1234_0000 |
| 0x340 | machine scratch | all | 0 |
| 0xF11 | machine identity, read-only | none | 0xCAFE_0001 |
| 0xC00 | free-running cycle count, read-only | none | 0 |

Top module: `csrf_top`

## Requirements
- R1: After reset, the registers hold the values in the table above. 0xC00 holds 0. With op_i at 2'b00, the outputs rdata_o and illegal_o are both 0.
- R2: A non-idle access to any address outside the seven implemented addresses raises illegal_o.
- R3: The privilege mode is encoded as user=2'b00, supervisor=2'b01, hypervisor=2'b10 and machine=2'b11. A non-idle access with priv_i below addr_i[9:8] raises illegal_o. An access with priv_i at or above addr_i[9:8] passes this check.
- R4: An access counts as a write when it is a swap, or when it is a set or clear with src_zero_i=0. A write to an address whose bits [11:10] are 2'b11 raises illegal_o.
- R5: A set or clear with src_zero_i=1 writes nothing. It is therefore legal on a read-only address, and it returns that register's value.
- R6: op_i is encoded as 00=idle, 01=swap, 10=set bits, 11=clear bits. The new value is the operand for a swap, old OR operand for a set, and old AND NOT operand for a clear. When src_zero_i=1, the operand is zero whatever wdata_i holds.
- R7: Fixed fields keep their value on a write: bits [31:16] of 0x300 and bits [31:8] of 0x040. No error is raised for them.
- R8: rdata_o returns the register's value before the write, in the same cycle the access is presented. A legal write is visible from the following cycle onwards.
- R9: When illegal_o is 1, rdata_o is 0 and no register changes.
- R10: With op_i=00, rdata_o is 0, illegal_o is 0 and no register changes.
- R11: Register 0xC00 increases by one on every clock edge after reset. It can be read from every privilege mode and cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation: 00 idle, 01 swap, 10 set bits, 11 clear bits |
| addr_i | input | 12 | Register address |
| wdata_i | input | DATA_W | Write operand |
| src_zero_i | input | 1 | The operand comes from the zero register |
| priv_i | input | 2 | Current privilege mode |
| rdata_o | output | DATA_W | Old register value, or 0 when the access is idle or illegal |
| illegal_o | output | 1 | The access is not allowed |

## Verification
A wrong stored value shows up at rdata_o the next time that address is read. The bench model reads every register often, so the error is seen within a few cycles of the faulty write. A wrong verdict on rights or decode shows up in the same cycle, as an illegal_o value that differs from the model's. A write that leaks through on an illegal access shows up at the next legal read of that register. A fixed field that drifts shows up as soon as its register is read back.

// File: rtl/csrf_pkg.sv
package csrf_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_SWAP = 2'b01,
        OP_SETB = 2'b10,
        OP_CLRB = 2'b11
    } csr_op_e;

    typedef enum logic [1:0] {
        PRV_USER = 2'b00,
        PRV_SUPV = 2'b01,
        PRV_HYPV = 2'b10,
        PRV_MACH = 2'b11
    } priv_e;

    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned NREG    = 7;
    localparam int unsigned CNT_IDX = 6;
    localparam int unsigned MSCR_IDX = 4;

    localparam logic [ADDR_W-1:0] REG_ADDR [NREG] = '{
        12'h040, 12'h140, 12'h240, 12'h300, 12'h340, 12'hF11, 12'hC00
    };

    localparam logic [63:0] REG_WMASK [NREG] = '{
        64'h0000_00FF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h0000_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0
    };

    localparam logic [63:0] REG_RSTV [NREG] = '{
        64'hA500_0000, 64'h0, 64'h0, 64'h1234_0000, 64'h0, 64'hCAFE_0001, 64'h0
    };

endpackage

// File: rtl/csrf_decode.sv
module csrf_decode
    import csrf_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NREG-1:0]   sel_o,
    output logic              hit_o
);

    for (genvar g = 0; g < NREG; g++) begin : g_match
        assign sel_o[g] = (addr_i == REG_ADDR[g]);
    end

    assign hit_o = |sel_o;

endmodule

// File: rtl/csrf_access_check.sv
module csrf_access_check
    import csrf_pkg::*;
(
    input  csr_op_e           op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              src_zero_i,
    input  priv_e             priv_i,
    input  logic              hit_i,
    output logic              active_o,
    output logic              illegal_o,
    output logic              do_write_o
);

    logic wants_write;
    logic ro_addr;
    logic low_priv;

    always_comb begin
        unique case (op_i)
            OP_IDLE: wants_write = 1'b0;
            OP_SWAP: wants_write = 1'b1;
            OP_SETB: wants_write = !src_zero_i;
            OP_CLRB: wants_write = !src_zero_i;
            default: wants_write = 1'b0;
        endcase
    end

    assign ro_addr    = (addr_i[ADDR_W-1:ADDR_W-2] == 2'b11);
    assign low_priv   = (priv_i < addr_i[ADDR_W-3:ADDR_W-4]);
    assign active_o   = (op_i != OP_IDLE);
    assign illegal_o  = active_o && (!hit_i || low_priv || (ro_addr && wants_write));
    assign do_write_o = active_o && wants_write && !illegal_o;

endmodule

// File: rtl/csrf_wmerge.sv
module csrf_wmerge
    import csrf_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  csr_op_e           op_i,
    input  logic              src_zero_i,
    input  logic [DATA_W-1:0] old_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] wmask_i,
    output logic [DATA_W-1:0] new_o
);

    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] cand;

    assign operand = src_zero_i ? '0 : wdata_i;

    always_comb begin
        unique case (op_i)
            OP_SWAP: cand = operand;
            OP_SETB: cand = old_i | operand;
            OP_CLRB: cand = old_i & ~operand;
            default: cand = old_i;
        endcase
    end

    assign new_o = (old_i & ~wmask_i) | (cand & wmask_i);

endmodule

// File: rtl/csrf_top.sv
module csrf_top
    import csrf_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op_i,
    input  logic [11:0]       addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              src_zero_i,
    input  logic [1:0]        priv_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              illegal_o
);

    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    csr_op_e           op;
    priv_e             priv;
    logic [NREG-1:0]   sel;
    logic              hit;
    logic              active;
    logic              illegal;
    logic              do_write;
    logic [DATA_W-1:0] rd_sel;
    logic [DATA_W-1:0] wm_sel;
    logic [DATA_W-1:0] new_val;
    logic [DATA_W-1:0] regs_q [NREG];

    assign op   = csr_op_e'(op_i);
    assign priv = priv_e'(priv_i);

    csrf_decode u_decode (
        .addr_i (addr_i),
        .sel_o  (sel),
        .hit_o  (hit)
    );

    csrf_access_check u_check (
        .op_i       (op),
        .addr_i     (addr_i),
        .src_zero_i (src_zero_i),
        .priv_i     (priv),
        .hit_i      (hit),
        .active_o   (active),
        .illegal_o  (illegal),
        .do_write_o (do_write)
    );

    always_comb begin
        rd_sel = '0;
        wm_sel = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel[i]) begin
                rd_sel = rd_sel | regs_q[i];
                wm_sel = wm_sel | REG_WMASK[i][DATA_W-1:0];
            end
        end
    end

    csrf_wmerge #(.DATA_W(DATA_W)) u_merge (
        .op_i       (op),
        .src_zero_i (src_zero_i),
        .old_i      (rd_sel),
        .wdata_i    (wdata_i),
        .wmask_i    (wm_sel),
        .new_o      (new_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= REG_RSTV[i][DATA_W-1:0];
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (i == CNT_IDX) begin
                    regs_q[i] <= regs_q[i] + ONE;
                end else if (do_write && sel[i]) begin
                    regs_q[i] <= new_val;
                end
            end
        end
    end

    always_comb begin
        rdata_o   = (active && !illegal) ? rd_sel : '0;
        illegal_o = illegal;
    end

    // Per-register checks: fixed fields and the illegal-access freeze.
    for (genvar g = 0; g < NREG; g++) begin : g_reg_chk
        if (g != CNT_IDX) begin : g_store
            a_r7_fixed_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
                (regs_q[g] & ~REG_WMASK[g][DATA_W-1:0]) ==
                ($past(regs_q[g]) & ~REG_WMASK[g][DATA_W-1:0]));
            a_r9_illegal_freezes: assert property (@(posedge clk) disable iff (!rst_n)
                illegal_o |=> $stable(regs_q[g]));
            a_r10_idle_freezes: assert property (@(posedge clk) disable iff (!rst_n)
                (op_i == 2'b00) |=> $stable(regs_q[g]));
        end
    end

    a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> regs_q[CNT_IDX] == $past(regs_q[CNT_IDX]) + ONE);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b00) |-> (rdata_o == '0 && !illegal_o));

    a_r3_low_priv_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 2'b00 && priv_i < addr_i[9:8]) |-> illegal_o);

    a_r8_swap_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 2'b01 && !illegal_o && !src_zero_i && addr_i == REG_ADDR[MSCR_IDX])
        |=> regs_q[MSCR_IDX] == $past(wdata_i));

endmodule

// File: tb/csrf_top_tb_top.sv
`timescale 1ns/1ps
module csrf_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [11:0] addr_i = 12'h000;
    logic [31:0] wdata_i = 32'h0;
    logic        src_zero_i = 1'b0;
    logic [1:0]  priv_i = 2'b11;
    logic [31:0] rdata_o;
    logic        illegal_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [11:0] maddr [7] = '{12'h040, 12'h140, 12'h240, 12'h300, 12'h340, 12'hF11, 12'hC00};
    logic [31:0] mmask [7] = '{32'h0000_00FF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_FFFF,
                               32'hFFFF_FFFF, 32'h0, 32'h0};
    logic [31:0] mreg  [7] = '{32'hA500_0000, 32'h0, 32'h0, 32'h1234_0000, 32'h0,
                               32'hCAFE_0001, 32'h0};
    logic [31:0] mcnt = 32'h0;

    csrf_top #(.DATA_W(32)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .src_zero_i (src_zero_i),
        .priv_i     (priv_i),
        .rdata_o    (rdata_o),
        .illegal_o  (illegal_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n) mcnt <= mcnt + 32'd1;
    end

    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual ill=%0b data=%h, expected ill=%0b data=%h",
                     tag, act[32], act[31:0], exp[32], exp[31:0]);
        end
    endtask

    function automatic int find(input logic [11:0] a);
        for (int i = 0; i < 7; i++) if (maddr[i] == a) return i;
        return -1;
    endfunction

    // One access: drive at negedge, compare against the model, then update the model.
    task automatic acc(input logic [1:0] op, input logic [11:0] a, input logic [31:0] wd,
                       input logic z, input logic [1:0] pv, input string tag);
        int k;
        logic active, ww, il;
        logic [31:0] old, operand, cand;
        @(negedge clk);
        op_i = op; addr_i = a; wdata_i = wd; src_zero_i = z; priv_i = pv;
        #2;
        k = find(a);
        active = (op != 2'b00);
        ww = (op == 2'b01) || !z;
        il = active && ((k < 0) || (pv < a[9:8]) || ((a[11:10] == 2'b11) && ww));
        old = (k == 6) ? mcnt : ((k >= 0) ? mreg[k] : 32'h0);
        check(tag, {illegal_o, rdata_o}, {il, (active && !il) ? old : 32'h0});
        if (active && !il && ww) begin
            operand = z ? 32'h0 : wd;
            case (op)
                2'b01:   cand = operand;
                2'b10:   cand = old | operand;
                default: cand = old & ~operand;
            endcase
            mreg[k] = (old & ~mmask[k]) | (cand & mmask[k]);
        end
    endtask

    task automatic lit(input string tag, input logic [31:0] exp);
        check(tag, {illegal_o, rdata_o}, {1'b0, exp});
    endtask

    initial begin
        logic [31:0] lfsr;
        logic [31:0] first;
        logic [11:0] pool [10] = '{12'h040, 12'h140, 12'h240, 12'h300, 12'h340,
                                   12'hF11, 12'hC00, 12'h7C0, 12'h341, 12'h000};
        lfsr = 32'hACE1_2345;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        acc(2'b00, 12'h340, 32'h0, 1'b0, 2'b11, "R1 idle after reset");
        acc(2'b10, 12'h040, 32'h0, 1'b1, 2'b11, "R1 user flags reset");
        lit("R1 user flags literal", 32'hA500_0000);
        acc(2'b10, 12'h300, 32'h0, 1'b1, 2'b11, "R1 control reset");
        lit("R1 control literal", 32'h1234_0000);
        acc(2'b10, 12'hF11, 32'h0, 1'b1, 2'b11, "R1 identity reset");
        lit("R1 identity literal", 32'hCAFE_0001);
        acc(2'b10, 12'h140, 32'h0, 1'b1, 2'b11, "R1 supervisor scratch reset");

        acc(2'b01, 12'h340, 32'h1111_2222, 1'b0, 2'b11, "R8 swap returns old");
        lit("R8 swap old literal", 32'h0);
        acc(2'b10, 12'h340, 32'h0000_F000, 1'b0, 2'b11, "R8 write visible next cycle");
        lit("R8 old value literal", 32'h1111_2222);
        acc(2'b11, 12'h340, 32'h1111_0000, 1'b0, 2'b11, "R6 clear bits");
        lit("R6 after set", 32'h1111_F222);
        acc(2'b10, 12'h340, 32'h0, 1'b1, 2'b11, "R6 read after clear");
        lit("R6 after clear", 32'h0000_F222);
        acc(2'b01, 12'h340, 32'hDEAD_BEEF, 1'b1, 2'b11, "R6 zero source swap");
        acc(2'b10, 12'h340, 32'h0, 1'b1, 2'b11, "R6 zero source wrote zero");
        lit("R6 zero literal", 32'h0);

        acc(2'b01, 12'h300, 32'hFFFF_FFFF, 1'b0, 2'b11, "R7 control write");
        acc(2'b10, 12'h300, 32'h0, 1'b1, 2'b11, "R7 control fixed field");
        lit("R7 control literal", 32'h1234_FFFF);
        acc(2'b01, 12'h040, 32'hFFFF_FFFF, 1'b0, 2'b00, "R7 user flags write");
        acc(2'b10, 12'h040, 32'h0, 1'b1, 2'b00, "R7 user flags fixed field");
        lit("R7 user flags literal", 32'hA500_00FF);

        acc(2'b10, 12'h140, 32'h0, 1'b1, 2'b00, "R3 user to supervisor reg");
        acc(2'b10, 12'h140, 32'h0, 1'b1, 2'b01, "R3 supervisor to supervisor reg");
        acc(2'b10, 12'h240, 32'h0, 1'b1, 2'b01, "R3 supervisor to hypervisor reg");
        acc(2'b01, 12'h240, 32'h5A5A_0F0F, 1'b0, 2'b10, "R3 hypervisor write");
        acc(2'b10, 12'h340, 32'h0, 1'b1, 2'b10, "R3 hypervisor to machine reg");
        acc(2'b10, 12'h240, 32'h0, 1'b1, 2'b11, "R3 machine to hypervisor reg");

        acc(2'b10, 12'h7C0, 32'h0, 1'b1, 2'b11, "R2 unimplemented 7C0");
        acc(2'b01, 12'h341, 32'h1, 1'b0, 2'b11, "R2 unimplemented 341");
        acc(2'b11, 12'h000, 32'h0, 1'b1, 2'b11, "R2 unimplemented 000");

        acc(2'b01, 12'hF11, 32'h0, 1'b0, 2'b11, "R4 swap read-only");
        acc(2'b10, 12'hF11, 32'h4, 1'b0, 2'b11, "R4 set read-only");
        acc(2'b01, 12'hC00, 32'h0, 1'b1, 2'b00, "R4 swap counter");
        acc(2'b11, 12'hF11, 32'hFFFF_FFFF, 1'b1, 2'b11, "R5 clear zero-source read-only");
        lit("R5 identity literal", 32'hCAFE_0001);
        acc(2'b10, 12'hC00, 32'h0, 1'b1, 2'b00, "R5 set zero-source counter");

        acc(2'b01, 12'h340, 32'h7777_7777, 1'b0, 2'b00, "R9 illegal swap");
        acc(2'b10, 12'h340, 32'h0, 1'b1, 2'b11, "R9 state unchanged");
        lit("R9 literal", 32'h0);
        acc(2'b00, 12'h340, 32'h9999_9999, 1'b0, 2'b11, "R10 idle");
        acc(2'b10, 12'h340, 32'h0, 1'b1, 2'b11, "R10 state unchanged");
        lit("R10 literal", 32'h0);

        acc(2'b10, 12'hC00, 32'h0, 1'b1, 2'b01, "R11 counter read");
        first = rdata_o;
        acc(2'b10, 12'hC00, 32'h0, 1'b1, 2'b10, "R11 counter again");
        lit("R11 counter step", first + 32'd1);

        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            acc(lfsr[1:0], pool[lfsr[7:4] % 10], {lfsr[15:0], lfsr[31:16]},
                (lfsr[9:8] == 2'b00), lfsr[11:10], "R6 mixed traffic");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule